// File: doc/BRIEF.md
# Strobed Register Bus Slave

This block is a small register file that sits on a synchronous processor bus. The bus frames each access with an address strobe. Every input except the read output-enable is sampled on the rising edge of one clock. An access takes two clock periods:

- **Address cycle.** The chip select and the strobe are both low. The address and the write/read direction are captured.
- **Data cycle.** The strobe is high and the chip select is still low. The access runs against the address captured last.

A width-select input switches the data path between 16-bit words and 8-bit bytes. In 8-bit mode, address bit 0 picks the byte lane. The read data is offered to a tri-state pad through a separate enable. That enable is gated by an asynchronous output-enable input.

Register index 0 is an event status register. Hardware sets its bits, and software clears a bit by writing 1 to it. Index 1 is the interrupt enable mask. All other indices are plain storage. An open-drain-style interrupt pull output is active while any enabled status bit is set. A protocol-error pulse reports a strobe that stayed high with chip select low on two consecutive edges.

The sequencer has four named states:

| State | Meaning |
|-------|---------|
| S_IDLE | No access is framed. |
| S_READ | A read data cycle is in progress. |
| S_WRITE | A write data cycle is in progress. |
| S_DONE | The data cycle has been consumed. |

Its transitions are checked at every edge, in this order of precedence:

1. **LOAD.** Chip select low and strobe low: the sequencer goes to S_WRITE or S_READ, according to the direction input.
2. **ABORT.** Chip select high: the sequencer goes to S_IDLE.
3. **EXEC.** Chip select low and strobe high: any state goes to S_DONE. An EXEC taken from S_DONE is a protocol error and performs no access.

Top module: `strobed_reg_slave`

## Requirements
- R1: After reset, the sequencer is in S_IDLE and the captured address is zero. data_oe, irq_pull and prot_err are low, and every register reads as 0.
- R2: Each rising edge with cs_n=0 and as_n=0 loads addr. If the strobe stays low over several edges, the address is reloaded each time, and the address loaded last is used by the following data cycle.
- R3: After a LOAD with wr_rd=1, the next edge with cs_n=0 and as_n=1 writes data_in. If cs_n is high at that edge, nothing is written.
- R4: In the clock period after a LOAD with wr_rd=0, data_out carries the addressed register's contents. data_oe is high during that period while oe_n is low.
- R5: data_oe follows oe_n without waiting for a clock edge. It is low whenever oe_n is high, and it is never high outside a read data cycle.
- R6: With byte_mode=1, the register index is addr[ADDR_W-1:1] and addr[0] selects the byte (0 = bits 7:0, 1 = bits 15:8). A write stores data_in[7:0] into that byte only. A read returns that byte on data_out[7:0], with data_out[15:8] zero.
- R7: With byte_mode=0, the register index is addr[ADDR_W-1:1] and addr[0] is ignored. Writes and reads carry all 16 bits.
- R8: If EXEC is sampled on two consecutive edges, prot_err is high for the one clock period after the second edge. That second edge performs no write.
- R9: Register index 0 is status: each event_set bit sampled high sets that status bit, and writing 1 to a bit clears it. Register index 1 is the interrupt enable. irq_pull is high, meaning the line is pulled low, while the status register ANDed with the enable register is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| as_n | input | 1 | Active-low address strobe |
| wr_rd | input | 1 | 1 = write, 0 = read; sampled in the address cycle |
| byte_mode | input | 1 | 1 = 8-bit data path, 0 = 16-bit |
| oe_n | input | 1 | Asynchronous active-low read output enable |
| addr | input | ADDR_W | Bus address |
| data_in | input | 16 | Write data |
| data_out | output | 16 | Read data |
| data_oe | output | 1 | Tri-state enable for the read data pads |
| event_set | input | 16 | Hardware event bits that set the status register |
| irq_pull | output | 1 | Open-drain interrupt: 1 pulls the line low, 0 releases it |
| prot_err | output | 1 | Protocol-error pulse |

## Verification
Random word and byte accesses, with random direction, address and lane, are compared with a bench model. Writes in one width are read back in the other, which separates byte-lane masking from index decoding, and the bit-0 aliasing of word mode from byte selection. Directed cases cover:

- a held strobe, which tells a reload apart from keeping the first address;
- an aborted write, which tells a cs_n-qualified commit apart from a blind one;
- a toggled oe_n within one data cycle, which shows that the enable is not registered;
- a doubled EXEC, after an access and from idle, which separates a protocol error from a normal data cycle.

// File: rtl/strb_pkg.sv
package strb_pkg;
    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_DONE
    } bus_state_e;
endpackage

// File: rtl/strb_seq.sv
module strb_seq
    import strb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              as_n,
    input  logic              wr_rd,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rd_active,
    output logic              wr_en,
    output logic              prot_err
);
    bus_state_e state, state_nx;
    logic       do_load, do_exec;

    assign do_load = !cs_n && !as_n;
    assign do_exec = !cs_n &&  as_n;

    // Next-state decision: LOAD, then ABORT, then EXEC.
    always_comb begin
        state_nx = state;
        if (do_load) begin
            state_nx = wr_rd ? S_WRITE : S_READ;
        end else if (cs_n) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  state_nx = S_DONE;
                S_READ:  state_nx = S_DONE;
                S_WRITE: state_nx = S_DONE;
                S_DONE:  state_nx = S_DONE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Outputs and captured address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            prot_err <= 1'b0;
        end else begin
            if (do_load) addr_q <= addr;
            prot_err <= (state == S_DONE) && do_exec;
        end
    end

    assign rd_active = (state == S_READ);
    assign wr_en     = (state == S_WRITE) && do_exec;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !as_n) |=> (addr_q == $past(addr)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs_n && !as_n) |=> $stable(addr_q));

    p_double_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> ($past(!cs_n && as_n) && $past(!cs_n && as_n, 2)));
endmodule

// File: rtl/strb_regs.sv
module strb_regs
    import strb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              byte_mode,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  event_set,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq_req
);
    localparam int IDX_W      = ADDR_W - 1;
    localparam int NREG       = 1 << IDX_W;
    localparam int STATUS_IDX = 0;
    localparam int ENABLE_IDX = 1;

    logic [BUS_W-1:0] regs [NREG];
    logic [IDX_W-1:0] idx;
    logic             hi_lane;
    logic [BUS_W-1:0] wmask, wval, word;

    assign idx     = addr_q[ADDR_W-1:1];
    assign hi_lane = addr_q[0];
    assign wmask   = !byte_mode ? {BUS_W{1'b1}}
                   : (hi_lane ? {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}}
                              : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}});
    assign wval    = byte_mode ? {2{wdata[BYTE_W-1:0]}} : wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (i == STATUS_IDX) begin
                    if (wr_en && idx == IDX_W'(i))
                        regs[i] <= (regs[i] & ~(wval & wmask)) | event_set;
                    else
                        regs[i] <= regs[i] | event_set;
                end else if (wr_en && idx == IDX_W'(i)) begin
                    regs[i] <= (regs[i] & ~wmask) | (wval & wmask);
                end
            end
        end
    end

    assign word    = regs[idx];
    assign rdata   = !byte_mode ? word
                   : {{BYTE_W{1'b0}}, (hi_lane ? word[BUS_W-1:BYTE_W] : word[BYTE_W-1:0])};
    assign irq_req = |(regs[STATUS_IDX] & regs[ENABLE_IDX]);

    p_no_stray_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs[ENABLE_IDX]));
endmodule

// File: rtl/strobed_reg_slave.sv
module strobed_reg_slave
    import strb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              as_n,
    input  logic              wr_rd,
    input  logic              byte_mode,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       data_in,
    output logic [15:0]       data_out,
    output logic              data_oe,
    input  logic [15:0]       event_set,
    output logic              irq_pull,
    output logic              prot_err
);
    logic [ADDR_W-1:0] addr_q;
    logic              rd_active, wr_en;
    logic [BUS_W-1:0]  rdata;

    strb_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .as_n      (as_n),
        .wr_rd     (wr_rd),
        .addr      (addr),
        .addr_q    (addr_q),
        .rd_active (rd_active),
        .wr_en     (wr_en),
        .prot_err  (prot_err)
    );

    strb_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr_q    (addr_q),
        .byte_mode (byte_mode),
        .wdata     (data_in),
        .event_set (event_set),
        .rdata     (rdata),
        .irq_req   (irq_pull)
    );

    // oe_n gates the pad enable without a register in the path.
    assign data_oe  = !oe_n && rd_active;
    assign data_out = rd_active ? rdata : '0;

    p_oe_after_read_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(!cs_n && !as_n && !wr_rd));

    p_oe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !data_oe);
endmodule

// File: tb/test_strobed_reg_slave.sv
`timescale 1ns/1ps
module test_strobed_reg_slave;
    localparam int AW = 4;
    localparam int NR = 1 << (AW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, as_n = 1'b1, wr_rd = 1'b0, byte_mode = 1'b0, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   data_in = '0, event_set = '0;
    logic [15:0]   data_out;
    logic          data_oe, irq_pull, prot_err;

    int checks = 0;
    int errors = 0;
    logic [15:0] m [NR];

    always #2 clk = ~clk;

    strobed_reg_slave #(.ADDR_W(AW)) i_strobed_reg_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .wr_rd(wr_rd),
        .byte_mode(byte_mode), .oe_n(oe_n), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .event_set(event_set),
        .irq_pull(irq_pull), .prot_err(prot_err)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [AW-1:0] a, input logic bm);
        logic [15:0] w;
        w = m[a[AW-1:1]];
        if (!bm) return w;
        return {8'h00, (a[0] ? w[15:8] : w[7:0])};
    endfunction

    function automatic logic exp_irq();
        return |(m[0] & m[1]);
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic bm, input logic [15:0] wd);
        logic [15:0] mask, val;
        mask = !bm ? 16'hFFFF : (a[0] ? 16'hFF00 : 16'h00FF);
        val  = bm ? {2{wd[7:0]}} : wd;
        if (a[AW-1:1] == 0) m[0] = m[0] & ~(val & mask);
        else                m[a[AW-1:1]] = (m[a[AW-1:1]] & ~mask) | (val & mask);
    endtask

    // Runs one framed access; returns what was seen during the data cycle.
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic bm,
                          input logic [15:0] wd, input logic abort,
                          output logic [15:0] rd, output logic oe_seen);
        @(negedge clk);
        cs_n = 1'b0; as_n = 1'b0; addr = a; wr_rd = wr; byte_mode = bm;
        @(negedge clk);
        as_n = 1'b1; data_in = wd;
        if (abort) cs_n = 1'b1;
        #0.5;
        rd = data_out; oe_seen = data_oe;
        @(negedge clk);
        cs_n = 1'b1;
        if (wr && !abort) model_write(a, bm, wd);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic        oe_seen;
        void'($urandom(32'd4711));
        for (int i = 0; i < NR; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 data_oe", {15'b0, data_oe}, 16'h0);
        check("R1 irq_pull", {15'b0, irq_pull}, 16'h0);
        check("R1 prot_err", {15'b0, prot_err}, 16'h0);
        for (int i = 0; i < NR; i++) begin
            access(1'b0, AW'(i * 2), 1'b0, 16'h0, 1'b0, rd, oe_seen);
            check("R1 reg zero", rd, 16'h0);
        end

        // R3 R7: word write with addr[0]=1, read back with addr[0]=0
        access(1'b1, 4'b0111, 1'b0, 16'hBEEF, 1'b0, rd, oe_seen);
        access(1'b0, 4'b0110, 1'b0, 16'h0, 1'b0, rd, oe_seen);
        check("R7 word alias", rd, 16'hBEEF);
        check("R4 data_oe in read", {15'b0, oe_seen}, 16'h1);

        // R6: byte write to high lane, then word and byte reads
        access(1'b1, 4'b0111, 1'b1, 16'hAA12, 1'b0, rd, oe_seen);
        access(1'b0, 4'b0110, 1'b0, 16'h0, 1'b0, rd, oe_seen);
        check("R6 high lane only", rd, 16'h12EF);
        access(1'b0, 4'b0110, 1'b1, 16'h0, 1'b0, rd, oe_seen);
        check("R6 low byte read", rd, 16'h00EF);
        access(1'b0, 4'b0111, 1'b1, 16'h0, 1'b0, rd, oe_seen);
        check("R6 high byte read", rd, 16'h0012);

        // R3: aborted write leaves register unchanged
        access(1'b1, 4'b0100, 1'b0, 16'h5555, 1'b1, rd, oe_seen);
        access(1'b0, 4'b0100, 1'b0, 16'h0, 1'b0, rd, oe_seen);
        check("R3 abort no write", rd, 16'h0000);

        // R5: data_oe follows oe_n within a read data cycle; low outside it
        check("R5 no oe outside read", {15'b0, data_oe}, 16'h0);
        @(negedge clk);
        cs_n = 1'b0; as_n = 1'b0; addr = 4'b0110; wr_rd = 1'b0; byte_mode = 1'b0;
        @(negedge clk);
        as_n = 1'b1;
        #0.5 oe_n = 1'b1;
        #0.3 check("R5 oe_n high", {15'b0, data_oe}, 16'h0);
        oe_n = 1'b0;
        #0.3 check("R5 oe_n low again", {15'b0, data_oe}, 16'h1);
        @(negedge clk);
        cs_n = 1'b1;

        // R2: strobe held low over two edges; the last address wins
        access(1'b1, 4'b0100, 1'b0, 16'h1357, 1'b0, rd, oe_seen);
        @(negedge clk);
        cs_n = 1'b0; as_n = 1'b0; addr = 4'b0100; wr_rd = 1'b0; byte_mode = 1'b0;
        @(negedge clk);
        addr = 4'b0110;
        @(negedge clk);
        as_n = 1'b1;
        #0.5 check("R2 reload", data_out, 16'h12EF);
        @(negedge clk);
        cs_n = 1'b1;

        // R8: double EXEC from idle
        @(negedge clk);
        cs_n = 1'b0; as_n = 1'b1;
        @(negedge clk);
        check("R8 single exec no err", {15'b0, prot_err}, 16'h0);
        @(negedge clk);
        check("R8 double exec err", {15'b0, prot_err}, 16'h1);
        cs_n = 1'b1;
        @(negedge clk);
        check("R8 err is a pulse", {15'b0, prot_err}, 16'h0);

        // R8: write, then a second EXEC with new data performs no write
        @(negedge clk);
        cs_n = 1'b0; as_n = 1'b0; addr = 4'b1000; wr_rd = 1'b1; byte_mode = 1'b0;
        @(negedge clk);
        as_n = 1'b1; data_in = 16'h1111;
        @(negedge clk);
        data_in = 16'h2222;
        @(negedge clk);
        check("R8 err after access", {15'b0, prot_err}, 16'h1);
        cs_n = 1'b1;
        model_write(4'b1000, 1'b0, 16'h1111);
        access(1'b0, 4'b1000, 1'b0, 16'h0, 1'b0, rd, oe_seen);
        check("R8 no second write", rd, 16'h1111);

        // R9: status events, enable, interrupt, write-one-to-clear
        @(negedge clk);
        event_set = 16'h0005;
        @(negedge clk);
        event_set = 16'h0000;
        m[0] = m[0] | 16'h0005;
        check("R9 irq masked", {15'b0, irq_pull}, 16'h0);
        access(1'b1, 4'b0010, 1'b0, 16'h0004, 1'b0, rd, oe_seen);
        check("R9 irq raised", {15'b0, irq_pull}, 16'h1);
        access(1'b1, 4'b0000, 1'b0, 16'h0004, 1'b0, rd, oe_seen);
        check("R9 irq cleared", {15'b0, irq_pull}, 16'h0);
        access(1'b0, 4'b0000, 1'b0, 16'h0, 1'b0, rd, oe_seen);
        check("R9 status after clear", rd, 16'h0001);

        // Random mix checked against the model
        @(negedge clk);
        event_set = 16'hA5F0;
        @(negedge clk);
        event_set = 16'h0000;
        m[0] = m[0] | 16'hA5F0;
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            logic          wr, bm, ab;
            logic [15:0]   wd, ex;
            a  = AW'($urandom);
            wr = 1'($urandom);
            bm = 1'($urandom);
            wd = 16'($urandom);
            ab = wr && ($urandom % 8 == 0);
            ex = exp_read(a, bm);
            access(wr, a, bm, wd, ab, rd, oe_seen);
            if (!wr) begin
                check(bm ? "R6 random byte read" : "R7 random word read", rd, ex);
                check("R4 random oe", {15'b0, oe_seen}, 16'h1);
            end else if (ab) begin
                check("R3 random abort oe", {15'b0, oe_seen}, 16'h0);
            end
            check("R9 random irq", {15'b0, irq_pull}, {15'b0, exp_irq()});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule